// File: doc/BRIEF.md
# Staged Reset Release Sequencer

This block holds two active-low reset lines low after power-on and lets them go one after the other, so that one downstream device finishes booting before the second one leaves reset. It runs from a single free-running slow reference clock, nominally 2.048 kHz. Its only control input is an active-low power-on-reset flag. Timing starts on the first clock edge at which that flag reads high, so counting begins only once the supply is valid.

Each of the two channels has its own prescaler, which makes single-cycle enable pulses in the reference clock domain, and its own down-counter loaded with a preload value. A channel keeps its pin pulled low until its counter has seen preload+1 prescaled ticks. It then stops driving the pin, and an external pull-up brings the line high. The defaults are divide-by-8 with preload 511 for the first channel, which is about 2 s. The second channel defaults to divide-by-512 with preload 39, which is about 10 s, or roughly 8 s after the first. A released line stays released. Only a new power-on reset brings the pins low again and restarts the timing.

Top module: `rst_stage_seq`

## Requirements
- R1: At every clock edge that samples `por_n` low, both `rst_oe` bits become 1 (pin pulled low) from the following cycle on, and stay 1 while `por_n` stays low.
- R2: `rst_val` is 0 on both bits at all times, so the block can only pull a pin low or leave it floating.
- R3: Count as cycle k the k-th clock edge that samples `por_n` high since it was last sampled low. Channel 0 (`rst_oe[0]`) changes from 1 to 0 right after edge k = (CH0_PRELOAD+1)*CH0_DIV. With the defaults this is edge 4096.
- R4: Channel 1 (`rst_oe[1]`) changes from 1 to 0 right after edge k = (CH1_PRELOAD+1)*CH1_DIV. With the defaults this is edge 20480.
- R5: Once a channel has released, its `rst_oe` bit stays 0 for as long as `por_n` stays high. The channel does not re-arm.
- R6: Bringing `por_n` low again at any point, for as little as one cycle, re-arms both channels. It also restarts their timing from k = 0, both before and after a channel has released.
- R7: With parameters ordered as in the defaults, channel 1 never releases while channel 0 still holds its pin low.
- R8: The boundary settings divide-by-1 and preload 0 follow the same rule. With divide 1 and preload 0 the release comes after edge 1. With divide 3 and preload 2 it comes after edge 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running reference clock (nominally 2.048 kHz) |
| por_n | input | 1 | Power-on reset, active low, sampled synchronously; high means supply good |
| rst_oe | output | 2 | Per-channel pin driver enable; 1 pulls the reset pin low, 0 floats it |
| rst_val | output | 2 | Per-channel driven value; always 0 (open-drain) |

## Verification
The checker examines every cycle for four things: both pins being pulled low after a sampled power-on reset, a released channel never re-arming while the supply stays good, the ordering between the two channels, and each release landing on exactly the expected count of cycles since reset ended. Some behaviour only the bench scenarios can show. One case is a short reset pulse that lands during the first channel's countdown. The other is a reset pulse that lands between the two releases. Both must restart the full sequence from zero. The bench also drives a second instance with divide-by-1 and preload-0 settings, because the default instance cannot show those boundary counts.

// File: rtl/rss_pkg.sv
// Package: shared types and width helpers for the staged reset sequencer.
// Assumes: nothing beyond IEEE 1800-2017 constant functions.
package rss_pkg;

    // Channel state: holding the pin low, or released for good.
    typedef enum logic {
        CH_HOLD     = 1'b0,
        CH_RELEASED = 1'b1
    } chan_state_t;

    // Number of bits needed to hold values 0..max_val, never less than one.
    function automatic int bits_for(input int max_val);
        int w;
        w = 1;
        while ((1 << w) <= max_val) begin
            w = w + 1;
        end
        return w;
    endfunction

endpackage

// File: rtl/rss_prescaler.sv
// Module: rss_prescaler
// Makes a one-cycle enable pulse on every DIV-th cycle while run is high.
// The pulse is valid in the same cycle in which the count reaches DIV-1.
// Assumes: DIV >= 1, synchronous active-low reset, single clock domain.
module rss_prescaler
    import rss_pkg::*;
#(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);

    localparam int CW = bits_for(DIV - 1);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] phase_q;

    // Pulse when the phase counter sits on its last value.
    always_comb begin
        tick = run && (phase_q == LAST);
    end

    // Phase counter: wraps at DIV-1 and is frozen while not running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (run) begin
            if (phase_q == LAST) begin
                phase_q <= '0;
            end else begin
                phase_q <= phase_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/rss_delay_chan.sv
// Module: rss_delay_chan
// One delay channel: a prescaler feeds a down-counter loaded with PRELOAD.
// The channel releases on the (PRELOAD+1)-th tick and stays released until
// the next reset. Its output enable is registered.
// Assumes: PRELOAD >= 0, DIV >= 1, synchronous active-low reset.
module rss_delay_chan
    import rss_pkg::*;
#(
    parameter int DIV     = 8,
    parameter int PRELOAD = 511
) (
    input  logic clk,
    input  logic rst_n,
    output logic pin_oe
);

    localparam int NW = bits_for(PRELOAD);
    localparam logic [NW-1:0] LOAD = NW'(PRELOAD);

    chan_state_t   state_q;
    logic [NW-1:0] left_q;
    logic          run;
    logic          tick;

    // Count only while the pin is still held.
    always_comb begin
        run = (state_q == CH_HOLD);
    end

    rss_prescaler #(
        .DIV (DIV)
    ) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    // Countdown and release: the tick that finds zero left ends the hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q  <= LOAD;
            state_q <= CH_HOLD;
        end else if (tick) begin
            if (left_q == '0) begin
                state_q <= CH_RELEASED;
            end else begin
                left_q <= left_q - 1'b1;
            end
        end
    end

    // Pull the pin low exactly while holding.
    always_comb begin
        pin_oe = (state_q == CH_HOLD);
    end

endmodule

// File: rtl/rst_stage_seq.sv
// Module: rst_stage_seq (top)
// Releases two open-drain reset pins in order after power-on reset ends.
// Each channel has its own prescaler ratio and preload value.
// Assumes: por_n is already synchronous to clk; external pull-ups exist.
module rst_stage_seq #(
    parameter int CH0_DIV     = 8,
    parameter int CH0_PRELOAD = 511,
    parameter int CH1_DIV     = 512,
    parameter int CH1_PRELOAD = 39
) (
    input  logic       clk,
    input  logic       por_n,
    output logic [1:0] rst_oe,
    output logic [1:0] rst_val
);

    localparam int NCH = 2;

    // One delay channel per reset pin; the index picks the settings.
    for (genvar c = 0; c < NCH; c++) begin : g_chan
        localparam int DIV_C = (c == 0) ? CH0_DIV : CH1_DIV;
        localparam int PRE_C = (c == 0) ? CH0_PRELOAD : CH1_PRELOAD;

        rss_delay_chan #(
            .DIV     (DIV_C),
            .PRELOAD (PRE_C)
        ) u_chan (
            .clk    (clk),
            .rst_n  (por_n),
            .pin_oe (rst_oe[c])
        );
    end

    // Open-drain: only ever drive a low level.
    always_comb begin
        rst_val = '0;
    end

endmodule

// File: rtl/rst_stage_seq_chk.sv
// Module: rst_stage_seq_chk
// Checker bound to rst_stage_seq. It keeps its own count of cycles since
// reset ended and checks release timing, the absence of re-arming and the
// channel order.
// Assumes: por_n is held low at the start of the run.
module rst_stage_seq_chk #(
    parameter int CH0_DIV     = 8,
    parameter int CH0_PRELOAD = 511,
    parameter int CH1_DIV     = 512,
    parameter int CH1_PRELOAD = 39
) (
    input logic       clk,
    input logic       por_n,
    input logic [1:0] rst_oe
);

    localparam int T0 = (CH0_PRELOAD + 1) * CH0_DIV;
    localparam int T1 = (CH1_PRELOAD + 1) * CH1_DIV;
    localparam bit ORDERED = (T1 >= T0);
    localparam int SAT = 32'h3FFF_FFFF;

    int since_q;

    // Cycles sampled with por_n high since the last sampled low, saturating.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            since_q <= 0;
        end else if (since_q < SAT) begin
            since_q <= since_q + 1;
        end
    end

    // R1: a sampled reset pulls both pins low on the next cycle.
    a_r1_por_holds: assert property (@(posedge clk)
        !por_n |=> (rst_oe == 2'b11));

    // R3: channel 0 falls exactly after edge T0.
    a_r3_ch0_timing: assert property (@(posedge clk) disable iff (!por_n)
        $fell(rst_oe[0]) |-> (since_q == T0));

    // R4: channel 1 falls exactly after edge T1.
    a_r4_ch1_timing: assert property (@(posedge clk) disable iff (!por_n)
        $fell(rst_oe[1]) |-> (since_q == T1));

    // R5: a released channel stays released while the supply is good.
    a_r5_no_rearm0: assert property (@(posedge clk)
        (por_n && !rst_oe[0]) |=> !rst_oe[0]);

    a_r5_no_rearm1: assert property (@(posedge clk)
        (por_n && !rst_oe[1]) |=> !rst_oe[1]);

    // R7: channel 1 is never released ahead of channel 0.
    if (ORDERED) begin : g_order
        a_r7_order: assert property (@(posedge clk) disable iff (!por_n)
            !rst_oe[1] |-> !rst_oe[0]);
    end

endmodule

bind rst_stage_seq rst_stage_seq_chk #(
    .CH0_DIV     (CH0_DIV),
    .CH0_PRELOAD (CH0_PRELOAD),
    .CH1_DIV     (CH1_DIV),
    .CH1_PRELOAD (CH1_PRELOAD)
) i_chk (
    .clk    (clk),
    .por_n  (por_n),
    .rst_oe (rst_oe)
);

// File: tb/test_rst_stage_seq.sv
// Bench: behavioural reference model compared against two instances on every
// clock. One instance uses the defaults; a small one covers the boundaries.
module test_rst_stage_seq;

    localparam int T0 = 512 * 8;
    localparam int T1 = 40 * 512;
    localparam int S0 = 1 * 1;
    localparam int S1 = 3 * 3;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic [1:0] oe_d, val_d, oe_s, val_s;

    int    vectors = 0;
    int    miscompares = 0;
    int    k = 0;
    bit    started = 1'b0;
    string tag = "R1";
    int    rel0_at = -1;
    int    rel1_at = -1;
    bit    done = 1'b0;

    always #5 clk = ~clk;

    rst_stage_seq i_rst_stage_seq (
        .clk(clk), .por_n(por_n), .rst_oe(oe_d), .rst_val(val_d)
    );

    rst_stage_seq #(
        .CH0_DIV(1), .CH0_PRELOAD(0), .CH1_DIV(3), .CH1_PRELOAD(2)
    ) i_small (
        .clk(clk), .por_n(por_n), .rst_oe(oe_s), .rst_val(val_s)
    );

    // Reference: count of edges sampled with por_n high since last low.
    always @(posedge clk) begin
        started <= 1'b1;
        if (!por_n) k <= 0;
        else k <= k + 1;
    end

    task automatic check(input string req, input string what,
                         input int act, input int exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s at k=%0d: actual %0d expected %0d",
                     req, what, k, act, exp);
        end
    endtask

    // Compare every clock, away from the active edge.
    always @(negedge clk) begin
        if (started && !done) begin
            check(tag, "default ch0 oe", int'(oe_d[0]), int'(k < T0));
            check(tag, "default ch1 oe", int'(oe_d[1]), int'(k < T1));
            check("R2", "default val", int'(val_d), 0);
            check("R8", "small ch0 oe", int'(oe_s[0]), int'(k < S0));
            check("R8", "small ch1 oe", int'(oe_s[1]), int'(k < S1));
            check("R2", "small val", int'(val_s), 0);
            if (por_n && !oe_d[0] && rel0_at < 0) rel0_at = k;
            if (por_n && !oe_d[1] && rel1_at < 0) rel1_at = k;
        end
    end

    task automatic run(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        por_n = 1'b0;
        tag = "R1";
        run(5);
        @(negedge clk); por_n = 1'b1;
        tag = "R3";
        run(4200);
        tag = "R4";
        run(16800);
        // R7: channel order seen at the ports
        check("R7", "ch1 after ch0", int'(rel1_at > rel0_at && rel0_at > 0), 1);
        tag = "R5";
        run(300);
        // R6: reset after both released, then mid-countdown of channel 0
        tag = "R6";
        por_n = 1'b0; run(3);
        por_n = 1'b1; run(2000);
        por_n = 1'b0; run(1);
        por_n = 1'b1;
        rel0_at = -1; rel1_at = -1;
        run(10000);
        por_n = 1'b0; run(1);
        por_n = 1'b1;
        run(21000);
        check("R7", "ch1 after ch0 after rearm",
              int'(rel1_at > rel0_at && rel0_at > 0), 1);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    // Watchdog
    initial begin
        #3_000_000;
        miscompares++;
        $display("FAIL watchdog expired: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule